// File: doc/BRIEF.md
# Salted-Index Branch Target Buffer

This block sits in an instruction fetch stage and supplies a predicted target for the fetched address. The table is direct-mapped. The slot for an address comes from XOR-folding address bits 29 down to 2 into an index-wide value and then XOR-ing in a salt register. Software reloads the salt with a fresh random value on each context switch. Without knowing the salt, a process cannot predict which slot another process's branch will occupy. Loading a new salt also empties the table.

Each slot keeps a tag made of the address bits above the lowest index-wide chunk of the window, up to a configurable top bit. A lookup hits only when the slot is valid and its tag matches. A valid slot whose tag differs is reported as an alias, so a conflict is never taken silently as a prediction. Resolved branches train the table: a taken branch writes its slot, and a not-taken branch that matches clears its slot.

Lookup results are registered. They appear one clock after the request.

Top module: `salted_btb`

## Requirements
- R1: After reset the salt is zero and no slot is valid, so every lookup reports no hit, no alias and a zero target until a slot is trained.
- R2: A taken update with no salt load in the same cycle writes the slot with the branch address and target. A later lookup of an address that equals it in bits TAG_HI down to 2 (bits 1:0 are ignored) reports hit=1 and that target in the cycle after the request.
- R3: The slot index is the XOR of all IDX_W-bit chunks of the window addr[29:2] (chunk k holds bits 2+k*IDX_W upward, and the last chunk is zero-padded), XOR-ed with the salt. Address bits outside 29:2 never change the index.
- R4: A hit needs a valid slot and equal bits TAG_HI down to 2+IDX_W. A valid slot with a differing tag gives hit=0, alias=1 and target 0 in the result cycle. Hit and alias are never high together.
- R5: A salt load clears every valid bit in the same edge. An update in that same cycle is dropped, and the new salt governs all later indexing.
- R6: A not-taken update clears its slot only when the slot is valid and its tag matches. Otherwise the slot is left as it was.
- R7: A lookup issued in the same cycle as an update, or as a salt load, sees the table contents from before that edge.
- R8: A cycle with no lookup request gives hit=0, alias=0 and target 0 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lu_en | input | 1 | Lookup request |
| lu_pc | input | ADDR_W | Fetch address to look up |
| pred_hit | output | 1 | Registered hit result |
| pred_alias | output | 1 | Registered tag-conflict flag |
| pred_target | output | ADDR_W | Registered predicted target, zero when there is no hit |
| up_en | input | 1 | Resolved-branch update strobe |
| up_pc | input | ADDR_W | Resolved branch address |
| up_target | input | ADDR_W | Resolved branch target |
| up_taken | input | 1 | Branch was taken |
| salt_we | input | 1 | Load a new salt and flush the table |
| salt_in | input | IDX_W | New salt value |

## Verification
The bench builds the block with 8 entries, 32-bit addresses and the tag running up to bit 31. That makes the index 3 bits wide, so every salt value can be swept. It also means the tag covers the whole address, so the bench model can decide a hit by comparing stored addresses directly. Because the window folds into ten 3-bit chunks, single-bit flips that keep the index but change the tag are easy to build. Under each salt the bench trains a pseudo-random address set, then mixes lookups of trained addresses, tag-flipped neighbours and fresh addresses with not-taken updates. Every result is compared with an arithmetic model.

// File: rtl/salted_btb.sv
module salted_btb #(
  parameter int ENTRIES = 64,
  parameter int ADDR_W  = 48,
  parameter int TAG_HI  = 47,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lu_en,
  input  logic [ADDR_W-1:0] lu_pc,
  output logic              pred_hit,
  output logic              pred_alias,
  output logic [ADDR_W-1:0] pred_target,
  input  logic              up_en,
  input  logic [ADDR_W-1:0] up_pc,
  input  logic [ADDR_W-1:0] up_target,
  input  logic              up_taken,
  input  logic              salt_we,
  input  logic [IDX_W-1:0]  salt_in
);
  localparam int WIN_LO = 2;
  localparam int WIN_HI = 29;
  localparam int WIN_W  = WIN_HI - WIN_LO + 1;
  localparam int NCHUNK = (WIN_W + IDX_W - 1) / IDX_W;
  localparam int TAG_LO = WIN_LO + IDX_W;
  localparam int TAG_W  = TAG_HI - TAG_LO + 1;

  function automatic logic [IDX_W-1:0] fold(input logic [WIN_W-1:0] win);
    logic [NCHUNK*IDX_W-1:0] padded;
    logic [IDX_W-1:0] acc;
    padded = '0;
    padded[WIN_W-1:0] = win;
    acc = '0;
    for (int k = 0; k < NCHUNK; k++) acc ^= padded[k*IDX_W +: IDX_W];
    return acc;
  endfunction

  logic [ENTRIES-1:0] vld;
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [ADDR_W-1:0]  tgt_q [ENTRIES];
  logic [IDX_W-1:0]   salt_q;

  logic [IDX_W-1:0] lu_idx, up_idx;
  logic [TAG_W-1:0] lu_tag, up_tag;
  logic             lu_vld, lu_match, up_hit;

  assign lu_idx   = fold(lu_pc[WIN_HI:WIN_LO]) ^ salt_q;
  assign up_idx   = fold(up_pc[WIN_HI:WIN_LO]) ^ salt_q;
  assign lu_tag   = lu_pc[TAG_HI:TAG_LO];
  assign up_tag   = up_pc[TAG_HI:TAG_LO];
  assign lu_vld   = vld[lu_idx];
  assign lu_match = tag_q[lu_idx] == lu_tag;
  assign up_hit   = vld[up_idx] && (tag_q[up_idx] == up_tag);

  wire unused_lsb = ^{lu_pc[1:0], up_pc[1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld    <= '0;
      salt_q <= '0;
    end else if (salt_we) begin
      vld    <= '0;
      salt_q <= salt_in;
    end else if (up_en) begin
      if (up_taken)    vld[up_idx] <= 1'b1;
      else if (up_hit) vld[up_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (up_en && up_taken && !salt_we) begin
      tag_q[up_idx] <= up_tag;
      tgt_q[up_idx] <= up_target;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pred_hit    <= 1'b0;
      pred_alias  <= 1'b0;
      pred_target <= '0;
    end else begin
      pred_hit    <= lu_en && lu_vld && lu_match;
      pred_alias  <= lu_en && lu_vld && !lu_match;
      pred_target <= (lu_en && lu_vld && lu_match) ? tgt_q[lu_idx] : '0;
    end
  end
endmodule

// File: rtl/salted_btb_sva.sv
module salted_btb_sva #(
  parameter int ENTRIES = 64,
  parameter int IDX_W   = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lu_en,
  input logic               pred_hit,
  input logic               pred_alias,
  input logic               up_en,
  input logic               up_taken,
  input logic               up_hit,
  input logic               salt_we,
  input logic [IDX_W-1:0]   up_idx,
  input logic [IDX_W-1:0]   salt_q,
  input logic [ENTRIES-1:0] vld
);
  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lu_en |=> (!pred_hit && !pred_alias));

  a_r4_hit_alias_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(pred_hit && pred_alias));

  a_r5_salt_flushes: assert property (@(posedge clk) disable iff (!rst_n)
    salt_we |=> (vld == '0));

  a_r2_taken_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (up_en && up_taken && !salt_we) |=> vld[$past(up_idx)]);

  a_r6_not_taken_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (up_en && !up_taken && up_hit && !salt_we) |=> !vld[$past(up_idx)]);

  a_r3_salt_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !salt_we |=> $stable(salt_q));
endmodule

bind salted_btb salted_btb_sva #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .lu_en(lu_en), .pred_hit(pred_hit),
  .pred_alias(pred_alias), .up_en(up_en), .up_taken(up_taken),
  .up_hit(up_hit), .salt_we(salt_we), .up_idx(up_idx),
  .salt_q(salt_q), .vld(vld)
);

// File: tb/salted_btb_test.sv
`timescale 1ns/1ps
module salted_btb_test;
  localparam int EN = 8;
  localparam int AW = 32;
  localparam int TH = 31;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lu_en = 1'b0, up_en = 1'b0, up_taken = 1'b0, salt_we = 1'b0;
  logic [AW-1:0] lu_pc = '0, up_pc = '0, up_target = '0;
  logic [IW-1:0] salt_in = '0;
  logic pred_hit, pred_alias;
  logic [AW-1:0] pred_target;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  salted_btb #(.ENTRIES(EN), .ADDR_W(AW), .TAG_HI(TH)) uut (
    .clk(clk), .rst_n(rst_n), .lu_en(lu_en), .lu_pc(lu_pc),
    .pred_hit(pred_hit), .pred_alias(pred_alias), .pred_target(pred_target),
    .up_en(up_en), .up_pc(up_pc), .up_target(up_target), .up_taken(up_taken),
    .salt_we(salt_we), .salt_in(salt_in)
  );

  bit            mv  [EN];
  logic [AW-1:0] mpc [EN];
  logic [AW-1:0] mtg [EN];
  logic [IW-1:0] msalt = '0;
  logic [31:0]   seed = 32'h1357_9bdf;

  function automatic logic [IW-1:0] midx(input logic [AW-1:0] a);
    logic [IW-1:0] f = '0;
    for (int b = 2; b < 30; b++) f[(b-2)%IW] ^= a[b];
    return f ^ msalt;
  endfunction

  function automatic logic [AW-1:0] nxt();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  task automatic step(input bit le, input logic [AW-1:0] lp,
                      input bit ue, input logic [AW-1:0] upc, input logic [AW-1:0] ut,
                      input bit utk, input bit sw, input logic [IW-1:0] sv,
                      input string req);
    bit eh, ea;
    logic [AW-1:0] et;
    logic [IW-1:0] i;
    @(negedge clk);
    lu_en = le; lu_pc = lp; up_en = ue; up_pc = upc; up_target = ut;
    up_taken = utk; salt_we = sw; salt_in = sv;
    i  = midx(lp);
    eh = le && mv[i] && (mpc[i][TH:2] == lp[TH:2]);
    ea = le && mv[i] && !eh;
    et = eh ? mtg[i] : '0;
    @(posedge clk);
    if (sw) begin
      for (int k = 0; k < EN; k++) mv[k] = 1'b0;
      msalt = sv;
    end else if (ue) begin
      i = midx(upc);
      if (utk) begin
        mv[i] = 1'b1; mpc[i] = upc; mtg[i] = ut;
      end else if (mv[i] && mpc[i][TH:2] == upc[TH:2]) begin
        mv[i] = 1'b0;
      end
    end
    @(negedge clk);
    lu_en = 1'b0; up_en = 1'b0; salt_we = 1'b0;
    checks++;
    if ({pred_hit, pred_alias, pred_target} !== {eh, ea, et}) begin
      fails++;
      $display("FAIL %s hit/alias/target actual=%0b/%0b/%h expected=%0b/%0b/%h",
               req, pred_hit, pred_alias, pred_target, eh, ea, et);
    end
  endtask

  task automatic look(input logic [AW-1:0] a, input string req);
    step(1'b1, a, 1'b0, '0, '0, 1'b0, 1'b0, '0, req);
  endtask

  task automatic train(input logic [AW-1:0] a, input logic [AW-1:0] t, input string req);
    step(1'b0, '0, 1'b1, a, t, 1'b1, 1'b0, '0, req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [AW-1:0] a, tr [16];
    for (int k = 0; k < EN; k++) mv[k] = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: empty table after reset
    look(32'h0000_1234, "R1");
    look(32'h3fff_fffc, "R1");
    look(32'h0000_0000, "R1");

    // R2: train and hit, low two bits ignored
    a = 32'h0000_1234;
    train(a, 32'h0000_8000, "R2");
    look(a, "R2");
    look(a | 32'h3, "R2");

    // R8: no request gives quiet outputs
    step(1'b0, a, 1'b0, '0, '0, 1'b0, 1'b0, '0, "R8");

    // R4: same index, different tag
    look(a ^ 32'h24, "R4");
    // R3: bits above 29 do not move the index
    look(a ^ 32'h4000_0000, "R3");
    look(a ^ 32'h8000_0000, "R3");

    // R6: not-taken on a conflicting address leaves the slot
    step(1'b0, '0, 1'b1, a ^ 32'h24, '0, 1'b0, 1'b0, '0, "R6");
    look(a, "R6");

    // R7: same-cycle taken update to the slot, lookup sees old target
    step(1'b1, a, 1'b1, a, 32'h0000_9000, 1'b1, 1'b0, '0, "R7");
    look(a, "R7");
    // R7 with R6: not-taken match clears, same-cycle lookup still hits
    step(1'b1, a, 1'b1, a, '0, 1'b0, 1'b0, '0, "R7");
    look(a, "R6");

    // R5: salt load flushes, lookup in same cycle sees old table
    train(a, 32'h0000_a000, "R5");
    step(1'b1, a, 1'b0, '0, '0, 1'b0, 1'b1, 3'd5, "R5");
    look(a, "R5");
    // R5: update in the salt-load cycle is dropped
    step(1'b0, '0, 1'b1, a, 32'h0000_b000, 1'b1, 1'b1, 3'd6, "R5");
    look(a, "R5");

    // R3: index under nonzero salt, flipped chunk bits keep the slot
    train(a, 32'h0000_c000, "R3");
    look(a ^ 32'h0000_0104, "R3");
    look(a ^ 32'h0000_0900, "R3");

    // R2 R3 R4 R6: sweep every salt
    for (int s = 0; s < EN; s++) begin
      step(1'b0, '0, 1'b0, '0, '0, 1'b0, 1'b1, IW'(s), "R5");
      for (int k = 0; k < 16; k++) begin
        tr[k] = nxt();
        train(tr[k], nxt(), "R2");
      end
      for (int k = 0; k < 64; k++) begin
        case (k % 3)
          0: a = tr[k%16];
          1: a = tr[k%16] ^ (32'h1 << (5 + k % 24));
          default: a = nxt();
        endcase
        if (k % 5 == 0)
          step(1'b1, a, 1'b1, tr[(k+3)%16], '0, 1'b0, 1'b0, '0, "R6");
        else
          look(a, "R4");
      end
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule